// File: doc/BRIEF.md
# Switch-or-Route Forwarding Decision

This block takes the parsed header of an incoming Ethernet frame (destination MAC, VLAN ID and destination IPv4 address) and produces a forwarding result. The result holds an egress port, a next-hop MAC, an egress VLAN and a set of flags. First the destination MAC is compared with the configured router MAC. A frame addressed to the router is routed. Routing tries an exact-match host table first and falls back to a longest-prefix-match route table on a miss. Any other frame is bridged by a lookup keyed on MAC and VLAN together.

All three tables are small register arrays inside the block. They are loaded through one shared write port. A table-select field steers each write to one table, and each write carries an index, the entry fields and a valid bit. Requests and results each use a valid/ready handshake. The pipeline has two register stages, so results come out in request order after a fixed latency.

Top module: `fwd_decide`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A frame whose in_dmac equals cfg_router_mac is routed (out_route=1). Every other frame is bridged (out_route=0), whatever its in_dip.
- R3: A bridged frame hits an L2 entry only when both the MAC and the VLAN match. On a hit the result is out_port from the entry, out_vlan = request VLAN, out_nh_mac = request MAC, out_hit=1 and out_flood=0.
- R4: A bridged frame that matches no entry gives out_flood=1, out_hit=0, out_port=0 and out_vlan = request VLAN.
- R5: A routed frame whose destination IP exactly matches a valid host entry returns that entry's port, next-hop MAC and VLAN, with out_hit=1 and out_via_lpm=0.
- R6: On a host miss, the route table entry with the longest matching prefix gives port, next-hop MAC and VLAN, with out_hit=1 and out_via_lpm=1.
- R7: A prefix length of 0 matches every address, so it acts as a default route. When two matching route entries have equal lengths, the lower index wins.
- R8: A routed frame that matches no host entry and no route entry gives out_hit=0, out_port=PUNT_PORT, out_nh_mac=0 and out_vlan=0.
- R9: When wr_en=1 at a clock edge, entry wr_index of the table chosen by wr_table (0 = L2, 1 = host, 2 = route) is written. A write with wr_valid=0 removes that entry from all later lookups.
- R10: A request accepted at clock edge k appears on the outputs after edge k+1. Back-to-back requests leave in the order they arrived.
- R11: While out_valid=1 and out_ready=0, all result outputs hold steady and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_router_mac | input | 48 | The router's own MAC address |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_dmac | input | 48 | Destination MAC |
| in_vlan | input | 12 | VLAN ID |
| in_dip | input | 32 | Destination IPv4 address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_port | output | PORT_W | Egress port |
| out_nh_mac | output | 48 | Next-hop MAC |
| out_vlan | output | 12 | Egress VLAN |
| out_route | output | 1 | Frame took the routing path |
| out_hit | output | 1 | A table entry matched |
| out_via_lpm | output | 1 | Result came from the route table |
| out_flood | output | 1 | L2 miss: flood within VLAN |
| wr_en | input | 1 | Table write strobe |
| wr_table | input | 2 | Table select: 0 L2, 1 host, 2 route |
| wr_index | input | IDX_W | Entry index |
| wr_valid | input | 1 | Valid bit stored with the entry |
| wr_mac | input | 48 | L2 entry MAC |
| wr_vlan | input | 12 | L2 key VLAN or routed egress VLAN |
| wr_ip | input | 32 | Host IP or route prefix |
| wr_plen | input | 6 | Route prefix length, 0 to 32 |
| wr_port | input | PORT_W | Entry egress port |
| wr_nh_mac | input | 48 | Entry next-hop MAC |

## Verification
The bench builds the block with four entries per table, a 6-bit port field and PUNT_PORT = 63. Four route entries are enough to hold a /8, two /16 prefixes of equal value and a /0 default at once. That puts the longest-match choice, the equal-length tie-break and the default route in reach with a single table load. Four L2 entries are enough for one MAC in two VLANs. The clearing writes then turn hits into an LPM fallback and a punt.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int IP_W   = 32;
  localparam int PLEN_W = 6;

  typedef enum logic [1:0] {
    TBL_L2   = 2'd0,
    TBL_HOST = 2'd1,
    TBL_LPM  = 2'd2
  } tbl_sel_e;

  // network mask for a prefix length; lengths of 32 and above give all ones
  function automatic logic [IP_W-1:0] prefix_mask(input logic [PLEN_W-1:0] plen);
    if (plen >= PLEN_W'(IP_W)) return '1;
    return ~({IP_W{1'b1}} >> plen);
  endfunction
endpackage

// File: rtl/l2_table.sv
module l2_table import fwd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_valid,
  input  logic [MAC_W-1:0]  wr_mac,
  input  logic [VID_W-1:0]  wr_vlan,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAC_W-1:0]  look_mac,
  input  logic [VID_W-1:0]  look_vlan,
  output logic              hit,
  output logic [PORT_W-1:0] hit_port
);
  logic [DEPTH-1:0]  ent_v;
  logic [MAC_W-1:0]  ent_mac  [DEPTH];
  logic [VID_W-1:0]  ent_vlan [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [DEPTH-1:0]  match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[i]    <= 1'b0;
        ent_mac[i]  <= '0;
        ent_vlan[i] <= '0;
        ent_port[i] <= '0;
      end else if (wr_en && wr_index == IDX_W'(i)) begin
        ent_v[i]    <= wr_valid;
        ent_mac[i]  <= wr_mac;
        ent_vlan[i] <= wr_vlan;
        ent_port[i] <= wr_port;
      end
    end
    assign match[i] = ent_v[i] && ent_mac[i] == look_mac && ent_vlan[i] == look_vlan;
  end

  always_comb begin
    hit      = |match;
    hit_port = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) hit_port = ent_port[i];
  end
endmodule

// File: rtl/host_table.sv
module host_table import fwd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_valid,
  input  logic [IP_W-1:0]   wr_ip,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAC_W-1:0]  wr_nh_mac,
  input  logic [VID_W-1:0]  wr_vlan,
  input  logic [IP_W-1:0]   look_ip,
  output logic              hit,
  output logic [PORT_W-1:0] hit_port,
  output logic [MAC_W-1:0]  hit_nh_mac,
  output logic [VID_W-1:0]  hit_vlan
);
  logic [DEPTH-1:0]  ent_v;
  logic [IP_W-1:0]   ent_ip   [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [MAC_W-1:0]  ent_nh   [DEPTH];
  logic [VID_W-1:0]  ent_vlan [DEPTH];
  logic [DEPTH-1:0]  match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[i]    <= 1'b0;
        ent_ip[i]   <= '0;
        ent_port[i] <= '0;
        ent_nh[i]   <= '0;
        ent_vlan[i] <= '0;
      end else if (wr_en && wr_index == IDX_W'(i)) begin
        ent_v[i]    <= wr_valid;
        ent_ip[i]   <= wr_ip;
        ent_port[i] <= wr_port;
        ent_nh[i]   <= wr_nh_mac;
        ent_vlan[i] <= wr_vlan;
      end
    end
    assign match[i] = ent_v[i] && ent_ip[i] == look_ip;
  end

  always_comb begin
    hit        = |match;
    hit_port   = '0;
    hit_nh_mac = '0;
    hit_vlan   = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) begin
        hit_port   = ent_port[i];
        hit_nh_mac = ent_nh[i];
        hit_vlan   = ent_vlan[i];
      end
  end
endmodule

// File: rtl/lpm_table.sv
module lpm_table import fwd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_valid,
  input  logic [IP_W-1:0]   wr_ip,
  input  logic [PLEN_W-1:0] wr_plen,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAC_W-1:0]  wr_nh_mac,
  input  logic [VID_W-1:0]  wr_vlan,
  input  logic [IP_W-1:0]   look_ip,
  output logic              hit,
  output logic [PORT_W-1:0] hit_port,
  output logic [MAC_W-1:0]  hit_nh_mac,
  output logic [VID_W-1:0]  hit_vlan
);
  logic [DEPTH-1:0]  ent_v;
  logic [IP_W-1:0]   ent_pfx  [DEPTH];
  logic [PLEN_W-1:0] ent_len  [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [MAC_W-1:0]  ent_nh   [DEPTH];
  logic [VID_W-1:0]  ent_vlan [DEPTH];
  logic [DEPTH-1:0]  match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[i]    <= 1'b0;
        ent_pfx[i]  <= '0;
        ent_len[i]  <= '0;
        ent_port[i] <= '0;
        ent_nh[i]   <= '0;
        ent_vlan[i] <= '0;
      end else if (wr_en && wr_index == IDX_W'(i)) begin
        ent_v[i]    <= wr_valid;
        ent_pfx[i]  <= wr_ip & prefix_mask(wr_plen);  // host bits cleared once, on write
        ent_len[i]  <= wr_plen;
        ent_port[i] <= wr_port;
        ent_nh[i]   <= wr_nh_mac;
        ent_vlan[i] <= wr_vlan;
      end
    end
    assign match[i] = ent_v[i] && (look_ip & prefix_mask(ent_len[i])) == ent_pfx[i];
  end

  // ascending scan, strictly-longer replaces: lowest index wins among equals
  always_comb begin
    logic [PLEN_W-1:0] best_len;
    hit        = 1'b0;
    best_len   = '0;
    hit_port   = '0;
    hit_nh_mac = '0;
    hit_vlan   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i] && (!hit || ent_len[i] > best_len)) begin
        hit        = 1'b1;
        best_len   = ent_len[i];
        hit_port   = ent_port[i];
        hit_nh_mac = ent_nh[i];
        hit_vlan   = ent_vlan[i];
      end
  end
endmodule

// File: rtl/fwd_decide.sv
module fwd_decide import fwd_pkg::*; #(
  parameter int PORT_W     = 6,
  parameter int L2_DEPTH   = 8,
  parameter int HOST_DEPTH = 8,
  parameter int LPM_DEPTH  = 8,
  parameter int IDX_W      = 3,
  parameter logic [PORT_W-1:0] PUNT_PORT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAC_W-1:0]  cfg_router_mac,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MAC_W-1:0]  in_dmac,
  input  logic [VID_W-1:0]  in_vlan,
  input  logic [IP_W-1:0]   in_dip,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port,
  output logic [MAC_W-1:0]  out_nh_mac,
  output logic [VID_W-1:0]  out_vlan,
  output logic              out_route,
  output logic              out_hit,
  output logic              out_via_lpm,
  output logic              out_flood,
  input  logic              wr_en,
  input  logic [1:0]        wr_table,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_valid,
  input  logic [MAC_W-1:0]  wr_mac,
  input  logic [VID_W-1:0]  wr_vlan,
  input  logic [IP_W-1:0]   wr_ip,
  input  logic [PLEN_W-1:0] wr_plen,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAC_W-1:0]  wr_nh_mac
);
  // stage 1: captured request
  logic              st_valid;
  logic [MAC_W-1:0]  st_dmac;
  logic [VID_W-1:0]  st_vlan;
  logic [IP_W-1:0]   st_dip;

  // named internal events for the checker
  logic stage_valid;
  logic advance;
  logic stage_is_route;

  assign advance        = !out_valid || out_ready;
  assign in_ready       = advance;
  assign stage_valid    = st_valid;
  assign stage_is_route = st_dmac == cfg_router_mac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_dmac  <= '0;
      st_vlan  <= '0;
      st_dip   <= '0;
    end else if (advance) begin
      st_valid <= in_valid;
      if (in_valid) begin
        st_dmac <= in_dmac;
        st_vlan <= in_vlan;
        st_dip  <= in_dip;
      end
    end
  end

  // table lookups
  logic              l2_hit, host_hit, lpm_hit;
  logic [PORT_W-1:0] l2_port, host_port, lpm_port;
  logic [MAC_W-1:0]  host_nh, lpm_nh;
  logic [VID_W-1:0]  host_vlan, lpm_vlan;

  l2_table #(.DEPTH(L2_DEPTH), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_l2 (
    .clk, .rst_n,
    .wr_en(wr_en && wr_table == TBL_L2), .wr_index, .wr_valid,
    .wr_mac, .wr_vlan, .wr_port,
    .look_mac(st_dmac), .look_vlan(st_vlan),
    .hit(l2_hit), .hit_port(l2_port)
  );

  host_table #(.DEPTH(HOST_DEPTH), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_host (
    .clk, .rst_n,
    .wr_en(wr_en && wr_table == TBL_HOST), .wr_index, .wr_valid,
    .wr_ip, .wr_port, .wr_nh_mac, .wr_vlan,
    .look_ip(st_dip),
    .hit(host_hit), .hit_port(host_port), .hit_nh_mac(host_nh), .hit_vlan(host_vlan)
  );

  lpm_table #(.DEPTH(LPM_DEPTH), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_lpm (
    .clk, .rst_n,
    .wr_en(wr_en && wr_table == TBL_LPM), .wr_index, .wr_valid,
    .wr_ip, .wr_plen, .wr_port, .wr_nh_mac, .wr_vlan,
    .look_ip(st_dip),
    .hit(lpm_hit), .hit_port(lpm_port), .hit_nh_mac(lpm_nh), .hit_vlan(lpm_vlan)
  );

  // decision
  logic [PORT_W-1:0] d_port;
  logic [MAC_W-1:0]  d_nh;
  logic [VID_W-1:0]  d_vlan;
  logic              d_hit, d_lpm, d_flood;

  always_comb begin
    d_lpm   = 1'b0;
    d_flood = 1'b0;
    if (stage_is_route) begin
      if (host_hit) begin
        d_hit = 1'b1; d_port = host_port; d_nh = host_nh; d_vlan = host_vlan;
      end else if (lpm_hit) begin
        d_hit = 1'b1; d_lpm = 1'b1; d_port = lpm_port; d_nh = lpm_nh; d_vlan = lpm_vlan;
      end else begin
        d_hit = 1'b0; d_port = PUNT_PORT; d_nh = '0; d_vlan = '0;
      end
    end else begin
      d_hit   = l2_hit;
      d_flood = !l2_hit;
      d_port  = l2_hit ? l2_port : '0;
      d_nh    = st_dmac;
      d_vlan  = st_vlan;
    end
  end

  // stage 2: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_port    <= '0;
      out_nh_mac  <= '0;
      out_vlan    <= '0;
      out_route   <= 1'b0;
      out_hit     <= 1'b0;
      out_via_lpm <= 1'b0;
      out_flood   <= 1'b0;
    end else if (advance) begin
      out_valid <= st_valid;
      if (st_valid) begin
        out_port    <= d_port;
        out_nh_mac  <= d_nh;
        out_vlan    <= d_vlan;
        out_route   <= stage_is_route;
        out_hit     <= d_hit;
        out_via_lpm <= d_lpm;
        out_flood   <= d_flood;
      end
    end
  end
endmodule

// File: rtl/fwd_decide_chk.sv
module fwd_decide_chk import fwd_pkg::*; #(
  parameter int PORT_W = 6,
  parameter logic [PORT_W-1:0] PUNT_PORT = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port,
  input logic [MAC_W-1:0]  out_nh_mac,
  input logic [VID_W-1:0]  out_vlan,
  input logic              out_route,
  input logic              out_hit,
  input logic              out_via_lpm,
  input logic              out_flood,
  input logic              stage_valid
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_nh_mac)
      && $stable(out_vlan) && $stable(out_route) && $stable(out_hit)
      && $stable(out_via_lpm) && $stable(out_flood));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> stage_valid);

  assert_emit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid && (!out_valid || out_ready) |=> out_valid);

  assert_flood_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flood |-> !out_route && !out_hit);

  assert_lpm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_via_lpm |-> out_route && out_hit);

  assert_punt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_route && !out_hit |-> out_port == PUNT_PORT && out_nh_mac == '0);
endmodule

bind fwd_decide fwd_decide_chk #(.PORT_W(PORT_W), .PUNT_PORT(PUNT_PORT)) u_chk (
  .clk, .rst_n, .in_valid, .in_ready, .out_valid, .out_ready,
  .out_port, .out_nh_mac, .out_vlan, .out_route, .out_hit, .out_via_lpm, .out_flood,
  .stage_valid
);

// File: tb/tb_fwd_decide.sv
`timescale 1ns/1ps
module tb_fwd_decide;
  localparam int PORT_W = 6;
  localparam int IDX_W  = 3;
  localparam logic [PORT_W-1:0] PUNT = 6'd63;

  logic clk = 0, rst_n = 0;
  logic [47:0] cfg_router_mac;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [47:0] in_dmac;  logic [11:0] in_vlan;  logic [31:0] in_dip;
  logic [PORT_W-1:0] out_port;  logic [47:0] out_nh_mac;  logic [11:0] out_vlan;
  logic out_route, out_hit, out_via_lpm, out_flood;
  logic wr_en, wr_valid;  logic [1:0] wr_table;  logic [IDX_W-1:0] wr_index;
  logic [47:0] wr_mac, wr_nh_mac;  logic [11:0] wr_vlan;  logic [31:0] wr_ip;
  logic [5:0] wr_plen;  logic [PORT_W-1:0] wr_port;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fwd_decide #(.PORT_W(PORT_W), .L2_DEPTH(4), .HOST_DEPTH(4), .LPM_DEPTH(4),
               .IDX_W(IDX_W), .PUNT_PORT(PUNT)) dut (.*);

  localparam logic [47:0] RMAC = 48'h02_00_00_00_00_01;
  localparam logic [47:0] MA   = 48'h00_11_22_33_44_55;
  localparam logic [47:0] MB   = 48'h00_aa_bb_cc_dd_ee;
  localparam logic [47:0] NH1  = 48'h00_00_00_00_01_01;
  localparam logic [47:0] NH2  = 48'h00_00_00_00_02_02;
  localparam logic [47:0] NH3  = 48'h00_00_00_00_03_03;
  localparam logic [47:0] NH4  = 48'h00_00_00_00_04_04;
  localparam logic [47:0] NH5  = 48'h00_00_00_00_05_05;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_entry(logic [1:0] tbl, int idx, logic v, logic [47:0] mac,
                             logic [11:0] vlan, logic [31:0] ip, logic [5:0] plen,
                             logic [PORT_W-1:0] port, logic [47:0] nh);
    @(negedge clk);
    wr_en = 1; wr_table = tbl; wr_index = IDX_W'(idx); wr_valid = v;
    wr_mac = mac; wr_vlan = vlan; wr_ip = ip; wr_plen = plen; wr_port = port; wr_nh_mac = nh;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drive(logic [47:0] dmac, logic [11:0] vlan, logic [31:0] dip);
    in_valid = 1; in_dmac = dmac; in_vlan = vlan; in_dip = dip;
  endtask

  task automatic expect_out(string req, logic [PORT_W-1:0] port, logic [47:0] nh,
                            logic [11:0] vlan, logic route, logic hit, logic lpm, logic flood);
    check(req, 64'(out_valid), 64'd1);
    check(req, 64'(out_port), 64'(port));
    check(req, 64'(out_nh_mac), 64'(nh));
    check(req, 64'(out_vlan), 64'(vlan));
    check(req, 64'({out_route, out_hit, out_via_lpm, out_flood}), 64'({route, hit, lpm, flood}));
  endtask

  // one request; accepted at edge k, result visible after edge k+1 (R10)
  task automatic lookup(string req, logic [47:0] dmac, logic [11:0] vlan, logic [31:0] dip,
                        logic [PORT_W-1:0] port, logic [47:0] nh, logic [11:0] evlan,
                        logic route, logic hit, logic lpm, logic flood);
    @(negedge clk);
    out_ready = 1;
    check({req, " ready"}, 64'(in_ready), 64'd1);
    drive(dmac, vlan, dip);
    @(negedge clk);
    in_valid = 0;
    check("R10 not before k+1", 64'(out_valid), 64'd0);
    @(negedge clk);
    expect_out(req, port, nh, evlan, route, hit, lpm, flood);
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_load();
    write_entry(2'd0, 0, 1, MA, 12'd10, 0, 0, 6'd5, 0);
    write_entry(2'd0, 1, 1, MA, 12'd20, 0, 0, 6'd7, 0);
    write_entry(2'd1, 0, 1, 0, 12'd100, 32'h0A000005, 0, 6'd3, NH1);
    write_entry(2'd2, 0, 1, 0, 12'd200, 32'h0A000000, 6'd8,  6'd9,  NH2);
    write_entry(2'd2, 1, 1, 0, 12'd300, 32'h0A010000, 6'd16, 6'd11, NH3);
    write_entry(2'd2, 2, 1, 0, 12'd400, 32'h00000000, 6'd0,  6'd13, NH4);
    write_entry(2'd2, 3, 1, 0, 12'd500, 32'h0A01FFFF, 6'd16, 6'd15, NH5);
  endtask

  task automatic t_bridge();
    lookup("R3 vlan10 hit", MA, 12'd10, 0, 6'd5, MA, 12'd10, 0, 1, 0, 0);
    lookup("R3 vlan20 hit", MA, 12'd20, 0, 6'd7, MA, 12'd20, 0, 1, 0, 0);
    lookup("R4 vlan miss", MA, 12'd30, 0, 6'd0, MA, 12'd30, 0, 0, 0, 1);
    lookup("R2 non-router MAC bridged", MB, 12'd10, 32'h0A000005, 6'd0, MB, 12'd10, 0, 0, 0, 1);
  endtask

  task automatic t_route();
    lookup("R5 host hit", RMAC, 12'd1, 32'h0A000005, 6'd3, NH1, 12'd100, 1, 1, 0, 0);
    lookup("R6 longest /16", RMAC, 12'd1, 32'h0A010203, 6'd11, NH3, 12'd300, 1, 1, 1, 0);
    lookup("R6 /8", RMAC, 12'd1, 32'h0A020001, 6'd9, NH2, 12'd200, 1, 1, 1, 0);
    lookup("R7 default /0", RMAC, 12'd1, 32'hC0A80001, 6'd13, NH4, 12'd400, 1, 1, 1, 0);
  endtask

  task automatic t_clear();
    write_entry(2'd2, 2, 0, 0, 0, 0, 0, 0, 0);
    lookup("R8 punt", RMAC, 12'd1, 32'hC0A80001, PUNT, 48'd0, 12'd0, 1, 0, 0, 0);
    write_entry(2'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    lookup("R9 host cleared", RMAC, 12'd1, 32'h0A000005, 6'd9, NH2, 12'd200, 1, 1, 1, 0);
    write_entry(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    lookup("R9 l2 cleared", MA, 12'd10, 0, 6'd0, MA, 12'd10, 0, 0, 0, 1);
  endtask

  task automatic t_order();
    @(negedge clk);
    out_ready = 1;
    drive(MA, 12'd20, 0);
    @(negedge clk);
    check("R10 b2b ready", 64'(in_ready), 64'd1);
    drive(RMAC, 12'd1, 32'h0A010203);
    @(negedge clk);
    in_valid = 0;
    expect_out("R10 first", 6'd7, MA, 12'd20, 0, 1, 0, 0);
    @(negedge clk);
    expect_out("R10 second", 6'd11, NH3, 12'd300, 1, 1, 1, 0);
    @(negedge clk);
    check("R10 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 0;
    drive(MA, 12'd20, 0);
    @(negedge clk);
    drive(RMAC, 12'd1, 32'h0A020001);
    @(negedge clk);
    drive(MA, 12'd30, 0);                 // must not be taken while stalled
    check("R11 stall in_ready", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    check("R11 stall in_ready held", 64'(in_ready), 64'd0);
    expect_out("R11 held", 6'd7, MA, 12'd20, 0, 1, 0, 0);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    expect_out("R11 second after release", 6'd9, NH2, 12'd200, 1, 1, 1, 0);
    @(negedge clk);
    check("R11 stalled request dropped", 64'(out_valid), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cfg_router_mac = RMAC;
    in_valid = 0; out_ready = 1; in_dmac = 0; in_vlan = 0; in_dip = 0;
    wr_en = 0; wr_table = 0; wr_index = 0; wr_valid = 0; wr_mac = 0; wr_vlan = 0;
    wr_ip = 0; wr_plen = 0; wr_port = 0; wr_nh_mac = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_bridge();
    t_route();
    t_order();
    t_backpressure();
    t_clear();
    finish_run();
  end
endmodule